// File: doc/BRIEF.md
# Fixed-Timeout Watchdog Reset Generator

This block is a free-running watchdog that firmware cannot switch off. It counts edges of the 32.768 kHz real-time-clock oscillator and nothing else. Firmware restarts the count by pulsing a kick strobe. The wake input also restarts the count, and holds it at zero for as long as it stays low. If 1.5 s (49152 slow-clock edges) pass with no restart, the block asserts the system reset, in the same way as the external reset pin.

A watchdog reset sets a cause flag. Downstream register logic reads this flag to choose wake-up state values instead of full cold-reset values. The system reset is held for a fixed 4100 slow-clock edges (about 125 ms). The block then drops the reset and raises the processor-run enable. A rising run enable means the processor starts fetching at address zero.

The cause flag stays set until the next pin reset. All pins are plain control and status pins: no data moves through the block, so no valid/ready handshake applies.

Top module: `wdt_reset_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sys_rst` is 0, `cpu_run` is 1 and `wdt_cause` is 0.
- R2: With `wake` high and `kick` low, the watchdog fires exactly `TIMEOUT_CYCLES` slow-clock edges after its count was last cleared. `sys_rst` reads 1 after that edge. A shorter quiet gap never fires it.
- R3: A `kick` sampled high on a slow-clock edge outside the hold clears the count on that edge. The next firing is therefore `TIMEOUT_CYCLES` edges later.
- R4: A `wake` sampled low outside the hold clears the count on every such edge. No firing occurs while `wake` stays low.
- R5: Once fired, `sys_rst` stays 1 for exactly `HOLD_CYCLES` sampled cycles. `cpu_run` is always the inverse of `sys_rst`.
- R6: `wdt_cause` becomes 1 on the firing edge and stays 1 across the hold and the later run. Only `rst_n` clears it.
- R7: `kick` and `wake` have no effect during the hold: its length is unchanged whatever they do.
- R8: On the edge that ends the hold, the count restarts from zero. With no kick, the next firing comes exactly `TIMEOUT_CYCLES` edges after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32.768 kHz real-time-clock time base |
| rst_n | input | 1 | External reset pin, active low, asynchronous |
| kick | input | 1 | Firmware refresh strobe, sampled on clk_slow |
| wake | input | 1 | Wake signal; low holds the count at zero |
| sys_rst | output | 1 | System reset request, active high |
| wdt_cause | output | 1 | 1 when the last reset came from the watchdog |
| cpu_run | output | 1 | Processor enable; rising edge starts fetch at address zero |

## Verification
Every cycle, the assertions check four things: the count and hold counters stay in range, a clear really zeroes the count, `cpu_run` and `sys_rst` stay complementary, and the cause flag never drops outside a pin reset. Some behaviour depends on exact edge counts and only the bench's scenarios can show it. These are the firing moment after each kick gap, the hold length, the restart from zero after release, and the immunity of the hold to kick and wake activity. The bench sweeps every kick gap around the timeout in a reduced configuration.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    WDT_ST_RUN  = 1'b0,
    WDT_ST_HOLD = 1'b1
  } wdt_state_e;
endpackage

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt #(
  parameter int TIMEOUT_CYCLES = 49152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic fire
);
  localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign fire = run && !clear && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || clear)   cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/wdt_hold_timer.sv
module wdt_hold_timer #(
  parameter int HOLD_CYCLES = 4100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] hcnt_q;

  assign done = active && (hcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hcnt_q <= '0;
    else if (!active || done) hcnt_q <= '0;
    else                     hcnt_q <= hcnt_q + 1'b1;
  end

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt_q <= LAST); // R5
endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen #(
  parameter int TIMEOUT_CYCLES = 49152,
  parameter int HOLD_CYCLES    = 4100
) (
  input  logic clk_slow,
  input  logic rst_n,
  input  logic kick,
  input  logic wake,
  output logic sys_rst,
  output logic wdt_cause,
  output logic cpu_run
);
  import wdt_pkg::*;

  wdt_state_e state_q;
  logic       fire;
  logic       hold_done;
  logic       in_run;
  logic       cnt_clear;

  assign in_run    = (state_q == WDT_ST_RUN);
  assign cnt_clear = kick || !wake;

  wdt_timeout_cnt #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_cnt (
    .clk   (clk_slow),
    .rst_n (rst_n),
    .run   (in_run),
    .clear (cnt_clear),
    .fire  (fire)
  );

  wdt_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk    (clk_slow),
    .rst_n  (rst_n),
    .active (!in_run),
    .done   (hold_done)
  );

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WDT_ST_RUN;
      sys_rst   <= 1'b0;
      cpu_run   <= 1'b1;
      wdt_cause <= 1'b0;
    end else begin
      case (state_q)
        WDT_ST_RUN: if (fire) begin
          state_q   <= WDT_ST_HOLD;
          sys_rst   <= 1'b1;
          cpu_run   <= 1'b0;
          wdt_cause <= 1'b1;
        end
        default: if (hold_done) begin
          state_q <= WDT_ST_RUN;
          sys_rst <= 1'b0;
          cpu_run <= 1'b1;
        end
      endcase
    end
  end

  AST_RUN_EXCL: assert property (@(posedge clk_slow) disable iff (!rst_n)
    cpu_run != sys_rst); // R5
  AST_FIRE_RESETS: assert property (@(posedge clk_slow) disable iff (!rst_n)
    fire |=> (sys_rst && wdt_cause)); // R2
  AST_CAUSE_STICKY: assert property (@(posedge clk_slow) disable iff (!rst_n)
    wdt_cause |=> wdt_cause); // R6
  AST_HOLD_IGNORES: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!in_run && !hold_done) |=> sys_rst); // R7
endmodule

// File: tb/test_wdt_reset_gen.sv
module test_wdt_reset_gen;
  localparam int T = 20;
  localparam int H = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic wake = 1'b1;
  logic sys_rst, wdt_cause, cpu_run;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  int since = 0;
  bit m_hold = 0;
  int m_hedges = 0;
  bit m_cause = 0;
  int rst_samples = 0;

  always #2 clk = ~clk;

  wdt_reset_gen #(.TIMEOUT_CYCLES(T), .HOLD_CYCLES(H)) i_wdt_reset_gen (
    .clk_slow(clk), .rst_n(rst_n), .kick(kick), .wake(wake),
    .sys_rst(sys_rst), .wdt_cause(wdt_cause), .cpu_run(cpu_run)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    #1;
    if (m_hold) begin
      m_hedges++;
      if (m_hedges == H) begin m_hold = 0; since = 0; end
    end else if (kick || !wake) begin
      since = 0;
    end else if (since == T - 1) begin
      m_hold = 1; m_hedges = 0; m_cause = 1;
    end else begin
      since++;
    end
    if (sys_rst) rst_samples++;
    chk(req, sys_rst, m_hold, "sys_rst");
    chk(req, cpu_run, !m_hold, "cpu_run");
    chk(req, wdt_cause, m_cause, "wdt_cause");
  endtask

  task automatic pin_reset();
    rst_n = 1'b0; kick = 1'b0; wake = 1'b1;
    #7;
    since = 0; m_hold = 0; m_hedges = 0; m_cause = 0;
    chk("R1", sys_rst, 1'b0, "sys_rst in reset");
    chk("R1", cpu_run, 1'b1, "cpu_run in reset");
    chk("R1", wdt_cause, 1'b0, "wdt_cause in reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_hold(input string req);
    while (m_hold) step(req);
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_reset();
    step("R1");

    // R2 R3: sweep every kick gap around the timeout
    for (int g = 1; g <= T + 3; g++) begin
      kick = 1'b1; step("R3");
      kick = 1'b0;
      for (int k = 0; k < g; k++) step(k + 1 >= T ? "R2" : "R3");
      finish_hold("R5");
    end

    // R5: hold length measured by sample count
    kick = 1'b1; step("R3"); kick = 1'b0;
    rst_samples = 0;
    for (int k = 0; k < T + H + 2; k++) step("R5");
    checks++;
    if (rst_samples != H) begin
      errors++;
      $display("FAIL R5 hold samples actual=%0d expected=%0d", rst_samples, H);
    end

    // R4: wake low keeps the count cleared
    kick = 1'b1; step("R3"); kick = 1'b0;
    for (int k = 0; k < T - 3; k++) step("R4");
    wake = 1'b0;
    for (int k = 0; k < 3 * T; k++) step("R4");
    wake = 1'b1;
    for (int k = 0; k < T + 1; k++) step("R4");
    // now in hold: R7 kicks and wake toggles ignored
    for (int k = 0; k < H + 3; k++) begin
      kick = 1'b1; wake = k[0];
      step("R7");
    end
    kick = 1'b0; wake = 1'b1;
    finish_hold("R7");

    // R8: fire again exactly T edges after release
    pin_reset();
    for (int k = 0; k < T; k++) step("R2");
    for (int k = 0; k < H - 1; k++) step("R5");
    step("R8");
    for (int k = 0; k < T; k++) step("R8");
    finish_hold("R8");

    // R6: cause remains set in later run, cleared only by pin
    for (int k = 0; k < 5; k++) begin kick = 1'b1; step("R6"); end
    kick = 1'b0;
    chk("R6", wdt_cause, 1'b1, "cause sticky");
    pin_reset();
    chk("R6", wdt_cause, 1'b0, "cause cleared by pin");
    step("R1");

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule